// File: doc/BRIEF.md
# Programmable 16-bit interval timer

This block is a single channel of a 16-bit hardware timer with a small register port. Software programs three registers: the running count, a mode word and a compare target. The count advances by one on each enabled cycle. Which cycles are enabled depends on the mode word and on the channel variant, which is fixed at build time. The source can be every system clock, an external dot-clock tick, an external line-sync tick, or the system clock divided by eight. The variant-2 channel can also be halted.

Two comparisons are made on every advance: against the target, and against the all-ones value. Each match sets sticky status bits in the mode word. Under mode control, a match can also fold the count back to zero and raise a one-cycle interrupt request. Interrupts run in one of two ways. In one-shot mode only the first qualifying event fires until the mode word is written again. In repeat mode every event fires. Reading the mode word through the strobed read port hands back the status bits and then clears them.

Top module: `ivtimer`

## Requirements
- R1: With no alternate source selected in the mode word, the count increases by one on every system clock, and the read data at address 0 shows it combinationally.
- R2: A write to address 0 loads the count with the written value on that edge. A write to address 2 changes the target and leaves the count advancing undisturbed.
- R3: An advance that would bring the count to the target value makes the count zero instead when mode bit 3 is set. With bit 3 clear the count passes the target, runs to 0xFFFF and then wraps to 0.
- R4: A target event (an advance arriving at the target) sets mode bit 11. An overflow event (an advance arriving at 0xFFFF) sets mode bit 12. Either event sets mode bit 10. All three stay set without further events.
- R5: A read of address 1 with the read strobe high returns the full mode word. From the next cycle bits 11 and 12 are clear, and bit 10 is kept. A read without the strobe clears nothing. An event in the same cycle as a strobed read leaves its bit set.
- R6: A write to address 1 stores the written mode word, sets the count to zero and re-arms the one-shot interrupt latch.
- R7: Mode bit 4 enables an interrupt on target events and bit 5 on overflow events. irq is high for exactly the one cycle after the edge on which the event happens. With the enable clear, no pulse appears.
- R8: With mode bit 6 set, every enabled event pulses irq. With it clear, only the first enabled event after a mode write pulses irq.
- R9: On variant 0, mode bit 8 makes the count advance only on cycles with dot_tick high. On variant 1, mode bit 8 makes it advance only on cycles with hsync_tick high.
- R10: On variant 2, mode bit 9 makes the count advance once every eight system clocks, with the first advance on the 8th edge after the mode write. Mode bit 0 stops the count entirely.
- R11: Address 3 reads as zero, and address 2 reads back the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| rd_en | input | 1 | Read strobe; enables the mode read side effect |
| addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| wdata | input | 16 | Write data |
| dot_tick | input | 1 | Single-cycle dot-clock advance enable (variant 0) |
| hsync_tick | input | 1 | Single-cycle line-sync advance enable (variant 1) |
| rdata | output | 16 | Combinational read data for addr |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
A strobed mode read that clears the status bits can land on the same edge as a target event that sets one. To provoke it, the bench programs target 3 with reset-on-target and writes the mode. It waits two cycles and then issues the strobed read across the third edge, the edge on which the count reaches the target. The read must return the word without the flag. The next plain read must show bits 10 and 11 set, which proves that the event wins over the clear.

// File: rtl/ivt_pkg.sv
// Shared constants for the interval timer: register addresses and the
// positions of mode-word bits the channel logic decodes.
package ivt_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_MODE   = 2'd1,
        REG_TARGET = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    localparam int MB_HALT    = 0;   // variant 2: stop counting
    localparam int MB_TGT_RST = 3;   // fold count to zero at target
    localparam int MB_IRQ_TGT = 4;   // irq on target event
    localparam int MB_IRQ_OVF = 5;   // irq on overflow event
    localparam int MB_REPEAT  = 6;   // irq repeats instead of one-shot
    localparam int MB_SRC_A   = 8;   // variants 0/1: external tick
    localparam int MB_SRC_B   = 9;   // variant 2: divide by eight
    localparam int MB_ANY_EVT = 10;  // set by either event
    localparam int MB_TGT_HIT = 11;  // sticky target flag
    localparam int MB_OVF_HIT = 12;  // sticky overflow flag
endpackage

// File: rtl/ivt_tick_sel.sv
// Advance-enable selection for one timer channel.
// Assumes dot/hsync ticks are single-cycle enables in the clk domain.
// The divide prescaler restarts on each mode write so its phase is known.
module ivt_tick_sel #(
    parameter int CHANNEL  = 0,
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel_a,
    input  logic sel_b,
    input  logic halt,
    input  logic dot_tick,
    input  logic hsync_tick,
    output logic adv
);
    localparam logic [DIV_LOG2-1:0] PRE_LAST = '1;

    logic [DIV_LOG2-1:0] pre_q;
    logic                pre_pulse;
    logic                alt_src;
    logic                alt_sel;
    logic                halted;

    // Prescaler: free-running divider, realigned by a mode write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    assign pre_pulse = (pre_q == PRE_LAST);

    // Source mux: the variant parameter fixes which tick a mode bit picks.
    always_comb begin
        alt_src = (CHANNEL == 0) ? dot_tick :
                  (CHANNEL == 1) ? hsync_tick : pre_pulse;
        alt_sel = (CHANNEL == 2) ? sel_b : sel_a;
        halted  = (CHANNEL == 2) && halt;
        adv     = !halted && (alt_sel ? alt_src : 1'b1);
    end

    // R10
    halt_no_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CHANNEL == 2 && halt) |-> !adv);
endmodule

// File: rtl/ivt_count.sv
// Counter datapath for one timer channel: load, clear, advance and the
// target / all-ones compares. Events are only reported on a real advance.
module ivt_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] target,
    input  logic         tgt_rst,
    output logic [W-1:0] cnt,
    output logic         tgt_evt,
    output logic         ovf_evt
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] nxt;
    logic         step;

    // Compare stage: the value the counter would step to.
    always_comb begin
        nxt     = cnt + 1'b1;
        step    = adv && !clear && !load;
        tgt_evt = step && (nxt == target);
        ovf_evt = step && (nxt == ALL_ONES);
    end

    // Count register: a write wins, then a fold at target, then a step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)         cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (tgt_evt && tgt_rst) cnt <= '0;
        else if (step)               cnt <= nxt;
    end

    // R3
    tgt_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_evt && tgt_rst) |=> (cnt == '0));
    // R2
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (cnt == $past(load_val)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clear && !load) |=> $stable(cnt));
endmodule

// File: rtl/ivt_ctrl.sv
// Mode word, sticky status bits and interrupt pulse for one channel.
// Assumes events arrive already qualified (no event on a write cycle).
module ivt_ctrl #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mode,
    input  logic [W-1:0] wdata,
    input  logic         rd_clr,
    input  logic         tgt_evt,
    input  logic         ovf_evt,
    output logic [W-1:0] mode,
    output logic         irq
);
    import ivt_pkg::*;

    logic [W-1:0] mode_nxt;
    logic         fired;
    logic         want;
    logic         fire;

    // Next mode word: the read-clear goes first so an event overrides it.
    always_comb begin
        mode_nxt = mode;
        if (rd_clr) begin
            mode_nxt[MB_TGT_HIT] = 1'b0;
            mode_nxt[MB_OVF_HIT] = 1'b0;
        end
        if (tgt_evt) begin
            mode_nxt[MB_TGT_HIT] = 1'b1;
            mode_nxt[MB_ANY_EVT] = 1'b1;
        end
        if (ovf_evt) begin
            mode_nxt[MB_OVF_HIT] = 1'b1;
            mode_nxt[MB_ANY_EVT] = 1'b1;
        end
        if (wr_mode) mode_nxt = wdata;
    end

    // Interrupt qualification against enables and the one-shot latch.
    always_comb begin
        want = (tgt_evt && mode[MB_IRQ_TGT]) || (ovf_evt && mode[MB_IRQ_OVF]);
        fire = want && !wr_mode && (mode[MB_REPEAT] || !fired);
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= '0;
        else        mode <= mode_nxt;
    end

    // Pulse output and one-shot latch; a mode write re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            fired <= 1'b0;
        end else begin
            irq   <= fire;
            fired <= wr_mode ? 1'b0 : (fired || fire);
        end
    end

    // R4
    tgt_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[MB_TGT_HIT] && !rd_clr && !wr_mode) |=> mode[MB_TGT_HIT]);
    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !wr_mode && !tgt_evt && !ovf_evt)
            |=> (!mode[MB_TGT_HIT] && !mode[MB_OVF_HIT]));
    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !mode[MB_REPEAT] && !wr_mode) |=> !irq);
    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tgt_evt || ovf_evt));
endmodule

// File: rtl/ivtimer.sv
// One channel of a 16-bit interval timer with a count/mode/target
// register port. Writes are synchronous; read data is combinational.
// CHANNEL picks the clock-source variant (0, 1 or 2).
module ivtimer #(
    parameter int CHANNEL  = 0,
    parameter int DIV_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    input  logic        dot_tick,
    input  logic        hsync_tick,
    output logic [15:0] rdata,
    output logic        irq
);
    import ivt_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mode;
    logic [CNT_W-1:0] target;
    logic             wr_cnt, wr_mode, wr_tgt, rd_clr;
    logic             adv, tgt_evt, ovf_evt;

    // Register decode.
    always_comb begin
        wr_cnt  = wr_en && (addr == REG_COUNT);
        wr_mode = wr_en && (addr == REG_MODE);
        wr_tgt  = wr_en && (addr == REG_TARGET);
        rd_clr  = rd_en && (addr == REG_MODE);
    end

    // Target register.
    always_ff @(posedge clk) begin
        if (!rst_n)      target <= '0;
        else if (wr_tgt) target <= wdata;
    end

    // Read mux.
    always_comb begin
        unique case (reg_addr_e'(addr))
            REG_COUNT:  rdata = cnt;
            REG_MODE:   rdata = mode;
            REG_TARGET: rdata = target;
            default:    rdata = '0;
        endcase
    end

    ivt_tick_sel #(.CHANNEL(CHANNEL), .DIV_LOG2(DIV_LOG2)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(wr_mode),
        .sel_a(mode[MB_SRC_A]), .sel_b(mode[MB_SRC_B]), .halt(mode[MB_HALT]),
        .dot_tick(dot_tick), .hsync_tick(hsync_tick), .adv(adv)
    );

    ivt_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .adv(adv), .clear(wr_mode), .load(wr_cnt),
        .load_val(wdata), .target(target), .tgt_rst(mode[MB_TGT_RST]),
        .cnt(cnt), .tgt_evt(tgt_evt), .ovf_evt(ovf_evt)
    );

    ivt_ctrl #(.W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wdata(wdata),
        .rd_clr(rd_clr), .tgt_evt(tgt_evt), .ovf_evt(ovf_evt),
        .mode(mode), .irq(irq)
    );

    // R6
    mode_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (cnt == '0 && mode == $past(wdata)));
    // R2
    tgt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tgt |=> (target == $past(wdata)));
endmodule

// File: tb/ivtimer_test.sv
module ivtimer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic        dot_tick = 1'b0;
    logic        hsync_tick = 1'b0;
    logic [15:0] rdata, rdata1, rdata2;
    logic        irq, irq1, irq2;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ivtimer #(.CHANNEL(0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .dot_tick(dot_tick), .hsync_tick(hsync_tick),
        .rdata(rdata), .irq(irq));
    ivtimer #(.CHANNEL(1)) uut_c1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .dot_tick(dot_tick), .hsync_tick(hsync_tick),
        .rdata(rdata1), .irq(irq1));
    ivtimer #(.CHANNEL(2)) uut_c2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .dot_tick(dot_tick), .hsync_tick(hsync_tick),
        .rdata(rdata2), .irq(irq2));

    // op: 0 write, 1 plain read, 2 strobed read
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  a;
        logic [15:0] d;
        logic [7:0]  idle;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 16'h0000, 8'd0, 16'h0000, 8'd6},
        '{2'd1, 2'd0, 16'h0000, 8'd4, 16'h0004, 8'd1},
        '{2'd0, 2'd0, 16'h1234, 8'd0, 16'h0000, 8'd2},
        '{2'd1, 2'd0, 16'h0000, 8'd2, 16'h1236, 8'd2},
        '{2'd0, 2'd2, 16'h0005, 8'd0, 16'h0000, 8'd2},
        '{2'd1, 2'd2, 16'h0000, 8'd0, 16'h0005, 8'd11},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'h1239, 8'd2},
        '{2'd0, 2'd1, 16'h0008, 8'd0, 16'h0000, 8'd6},
        '{2'd1, 2'd0, 16'h0000, 8'd4, 16'h0004, 8'd3},
        '{2'd1, 2'd1, 16'h0000, 8'd0, 16'h0C08, 8'd4},
        '{2'd2, 2'd1, 16'h0000, 8'd0, 16'h0C08, 8'd5},
        '{2'd1, 2'd1, 16'h0000, 8'd0, 16'h0408, 8'd5},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'h0003, 8'd3},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'h0004, 8'd3},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'h0000, 8'd3},
        '{2'd0, 2'd1, 16'h0000, 8'd0, 16'h0000, 8'd6},
        '{2'd0, 2'd0, 16'hFFFD, 8'd0, 16'h0000, 8'd2},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'hFFFD, 8'd2},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'hFFFE, 8'd3},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'hFFFF, 8'd3},
        '{2'd1, 2'd0, 16'h0000, 8'd0, 16'h0000, 8'd3},
        '{2'd1, 2'd1, 16'h0000, 8'd0, 16'h1400, 8'd4}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic irq_count(input int edges, output int pulses);
        pulses = 0;
        for (int i = 0; i < edges; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        // R11: reset state reads zero in every register
        addr = 2'd0; #1 chk("R11 reset count", rdata, 0);
        addr = 2'd1; #1 chk("R11 reset mode", rdata, 0);
        addr = 2'd3; #1 chk("R11 unused address", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            repeat (VECS[v].idle) @(negedge clk);
            addr = VECS[v].a;
            if (VECS[v].op == 2'd0) begin
                reg_wr(VECS[v].a, VECS[v].d);
            end else begin
                rd_en = (VECS[v].op == 2'd2);
                #1 chk($sformatf("R%0d vector %0d", VECS[v].req, v), rdata, VECS[v].exp);
                @(negedge clk);
                rd_en = 1'b0;
            end
        end

        // R9: external ticks drive variants 0 and 1
        reg_wr(2'd1, 16'h0100);
        dot_tick = 1'b1; repeat (2) @(negedge clk); dot_tick = 1'b0;
        hsync_tick = 1'b1; repeat (3) @(negedge clk); hsync_tick = 1'b0;
        addr = 2'd0; #1;
        chk("R9 dot tick on variant 0", rdata, 2);
        chk("R9 hsync tick on variant 1", rdata1, 3);

        // R10: divide by eight on variant 2, sysclk on variant 0
        reg_wr(2'd1, 16'h0200);
        repeat (16) @(negedge clk);
        addr = 2'd0; #1;
        chk("R10 divided count", rdata2, 2);
        chk("R1 sysclk count", rdata, 16);
        reg_wr(2'd1, 16'h0201);
        repeat (10) @(negedge clk);
        addr = 2'd0; #1;
        chk("R10 halted count", rdata2, 0);

        // R7/R8: target irq one-shot then repeat, then re-arm
        reg_wr(2'd2, 16'h0003);
        reg_wr(2'd1, 16'h0008);
        irq_count(12, p); chk("R7 target irq disabled", p, 0);
        reg_wr(2'd1, 16'h0018);
        irq_count(12, p); chk("R8 one-shot pulses", p, 1);
        reg_wr(2'd1, 16'h0058);
        irq_count(12, p); chk("R8 repeat pulses", p, 4);
        reg_wr(2'd1, 16'h0018);
        irq_count(12, p); chk("R6 re-armed one-shot", p, 1);

        // R7: overflow irq
        reg_wr(2'd1, 16'h0020);
        reg_wr(2'd0, 16'hFFFD);
        irq_count(4, p); chk("R7 overflow irq", p, 1);

        // R5: strobed read on the same edge as a target event
        reg_wr(2'd1, 16'h0008);
        repeat (2) @(negedge clk);
        addr = 2'd1; rd_en = 1'b1;
        #1 chk("R5 read before event", rdata, 16'h0008);
        @(negedge clk);
        rd_en = 1'b0;
        #1 chk("R5 event wins over clear", rdata, 16'h0C08);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule